// File: doc/BRIEF.md
# Prioritized Interrupt Controller

The controller samples 64 level-sensitive request lines into a pending register. It then picks one request to present to the processor. A source takes part only when three things hold: its line is pending, software has given it a non-zero control byte, and its mask bit is clear. Among those sources, the one with the largest control byte wins. The level output carries that byte, and the vector output carries the winner's index plus 64. When no source qualifies, the level is 0 and the vector is the spurious value 24.

Software reaches the block through a single-cycle register bus with byte offsets. It can read the pending and mask registers as 32-bit halves and write the mask halves. It can also set or clear a single mask bit, or every mask bit, with one byte write. Each source has a control byte that can be read and written. A software acknowledge read returns the current vector. The level and vector outputs are registered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The pending register holds, for each source, the value of `irq_i` at the last clock edge. Its high half is read at offset 0x00 and its low half at 0x04. Writes to 0x00 and 0x04 do not change it.
- R2: A source is a candidate only if it is pending, enabled and unmasked (mask bit 0). The force halves at 0x10 and 0x14 always read zero and add no candidates.
- R3: The control byte of source n is at offset 0x40+n, in `wdata[7:0]` and `rdata[7:0]`. Writing a non-zero value enables the source; writing zero disables it.
- R4: The winner is the candidate with the largest control byte. Among candidates with equal bytes, the one with the higher index wins.
- R5: With a winner, `irq_level_o` equals its control byte and `irq_vector_o` equals its index plus 64. With no candidate, the level is 0 and the vector is 24.
- R6: The mask high half (sources 63..32) is read and written at 0x08, and the low half (sources 31..0) at 0x0C. A mask bit of 1 blocks its source.
- R7: A write to 0x1C sets the mask bit given by `wdata[5:0]`. If `wdata[6]` is 1, it sets every mask bit instead.
- R8: A write to 0x1D clears the mask bit given by `wdata[5:0]`. If `wdata[6]` is 1, it clears every mask bit instead.
- R9: A read of 0xE0 returns the current `irq_vector_o`. Reads of 0xE1 to 0xE7 and of any unmapped offset return 0.
- R10: After reset, every mask bit is 1, the pending register and all control bytes are 0, every source is disabled, the level is 0 and the vector is 24.
- R11: The outputs follow a register write one clock later, and a change on `irq_i` two clocks later.
- R12: A write to an unmapped offset changes no mask, control byte or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Level request lines, one per source |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the current state |
| irq_level_o | output | 8 | Control byte of the winning source, 0 when idle |
| irq_vector_o | output | 8 | Winner index + 64, or 24 when idle |

## Verification
The hardest case to reach from the ports is a tie in priority between two live candidates while a third, higher-index source is pending but excluded. The third source may be excluded either by a zero control byte or by a single mask bit. To set this up, the stimulus first programs duplicate control bytes on non-adjacent sources and leaves one pending source disabled. It then drives request patterns that combine these sources. Next it masks the tie winner through the single-bit set command, so that the selection must fall back to the lower index. Finally it brings that source back with the clear command.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned SRC_N    = 64;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned VEC_BASE = 64;
  localparam int unsigned SPUR_VEC = 24;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;

  localparam logic [7:0] OFS_PEND_HI = 8'h00;
  localparam logic [7:0] OFS_PEND_LO = 8'h04;
  localparam logic [7:0] OFS_MASK_HI = 8'h08;
  localparam logic [7:0] OFS_MASK_LO = 8'h0C;
  localparam logic [7:0] OFS_FRC_HI  = 8'h10;
  localparam logic [7:0] OFS_FRC_LO  = 8'h14;
  localparam logic [7:0] OFS_MSET    = 8'h1C;
  localparam logic [7:0] OFS_MCLR    = 8'h1D;
  localparam logic [7:0] OFS_SWACK   = 8'hE0;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned N    = SRC_N,
  parameter int unsigned CW   = CTRL_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned VW   = VEC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         irq_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [VW-1:0]        vector_i,
  output logic [DW-1:0]        rdata_o,
  output logic [N-1:0]         pend_o,
  output logic [N-1:0]         mask_o,
  output logic [N-1:0]         en_o,
  output logic [N-1:0][CW-1:0] ctrl_o
);
  localparam int unsigned IW = $clog2(N);

  logic [N-1:0]         pend_q, mask_q, en_q;
  logic [N-1:0][CW-1:0] ctrl_q;
  logic                 wr, ctrl_hit, mask_hit;
  logic [IW-1:0]        sel_idx, cmd_idx;

  assign wr       = req_i & we_i;
  assign ctrl_hit = (addr_i >= AW'(8'h40)) && (addr_i < AW'(8'h40 + N));
  assign sel_idx  = IW'(addr_i - AW'(8'h40));
  assign cmd_idx  = wdata_i[IW-1:0];
  assign mask_hit = (addr_i == OFS_MASK_HI) || (addr_i == OFS_MASK_LO) ||
                    (addr_i == OFS_MSET)    || (addr_i == OFS_MCLR);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= irq_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (wr) begin
      case (addr_i)
        OFS_MASK_HI: mask_q[N-1:N/2] <= wdata_i[N/2-1:0];
        OFS_MASK_LO: mask_q[N/2-1:0] <= wdata_i[N/2-1:0];
        OFS_MSET: begin
          if (wdata_i[IW]) mask_q <= '1;
          else             mask_q[cmd_idx] <= 1'b1;
        end
        OFS_MCLR: begin
          if (wdata_i[IW]) mask_q <= '0;
          else             mask_q[cmd_idx] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[i] <= '0;
        en_q[i]   <= 1'b0;
      end else if (wr && ctrl_hit && sel_idx == IW'(i)) begin
        ctrl_q[i] <= wdata_i[CW-1:0];
        en_q[i]   <= |wdata_i[CW-1:0];
      end
    end
  end

  // force halves and level-acknowledge offsets read as zero
  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) rdata_o = DW'(ctrl_q[sel_idx]);
    else begin
      case (addr_i)
        OFS_PEND_HI: rdata_o = DW'(pend_q[N-1:N/2]);
        OFS_PEND_LO: rdata_o = DW'(pend_q[N/2-1:0]);
        OFS_MASK_HI: rdata_o = DW'(mask_q[N-1:N/2]);
        OFS_MASK_LO: rdata_o = DW'(mask_q[N/2-1:0]);
        OFS_SWACK:   rdata_o = DW'(vector_i);
        default:     rdata_o = '0;
      endcase
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign en_o   = en_q;
  assign ctrl_o = ctrl_q;

  assert_pend_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_q == $past(irq_i));
  assert_ctrl_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && ctrl_hit) |=> en_q[$past(sel_idx)] == ($past(wdata_i[CW-1:0]) != '0));
  assert_mset_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_MSET && wdata_i[IW]) |=> &mask_q);
  assert_mclr_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_MCLR && wdata_i[IW]) |=> mask_q == '0);
  assert_unmapped_wr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !ctrl_hit && !mask_hit) |=> $stable(mask_q) && $stable(ctrl_q) && $stable(en_q));
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import prio_irq_pkg::*;
#(
  parameter int unsigned N  = SRC_N,
  parameter int unsigned CW = CTRL_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][CW-1:0] ctrl_i,
  output logic                 any_o,
  output logic [IW-1:0]        idx_o,
  output logic [CW-1:0]        level_o
);
  // ascending scan with >= lets a higher index take an equal byte
  always_comb begin
    any_o   = 1'b0;
    idx_o   = '0;
    level_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i] && ctrl_i[i] >= level_o) begin
        any_o   = 1'b1;
        idx_o   = IW'(i);
        level_o = ctrl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg
  import prio_irq_pkg::*;
#(
  parameter int unsigned N   = SRC_N,
  parameter int unsigned CW  = CTRL_W,
  parameter int unsigned VW  = VEC_W,
  parameter int unsigned VB  = VEC_BASE,
  parameter int unsigned SV  = SPUR_VEC,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          any_i,
  input  logic [IW-1:0] idx_i,
  input  logic [CW-1:0] level_i,
  output logic [CW-1:0] level_o,
  output logic [VW-1:0] vector_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= '0;
      vector_o <= VW'(SV);
    end else if (any_i) begin
      level_o  <= level_i;
      vector_o <= VW'(VB) + VW'(idx_i);
    end else begin
      level_o  <= '0;
      vector_o <= VW'(SV);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [63:0] irq_i,
  input  logic        bus_req_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic [7:0]  irq_level_o,
  output logic [7:0]  irq_vector_o
);
  localparam int unsigned IW = $clog2(SRC_N);

  logic [SRC_N-1:0]             pend, mask, en, cand;
  logic [SRC_N-1:0][CTRL_W-1:0] ctrl;
  logic                         any;
  logic [IW-1:0]                win_idx;
  logic [CTRL_W-1:0]            win_lvl;

  irq_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .req_i    (bus_req_i),
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .vector_i (irq_vector_o),
    .rdata_o  (bus_rdata_o),
    .pend_o   (pend),
    .mask_o   (mask),
    .en_o     (en),
    .ctrl_o   (ctrl)
  );

  // force register is read-only and never set, so it contributes nothing
  assign cand = pend & en & ~mask;

  irq_pick u_pick (
    .cand_i  (cand),
    .ctrl_i  (ctrl),
    .any_o   (any),
    .idx_o   (win_idx),
    .level_o (win_lvl)
  );

  irq_out_reg u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .any_i    (any),
    .idx_i    (win_idx),
    .level_i  (win_lvl),
    .level_o  (irq_level_o),
    .vector_o (irq_vector_o)
  );

  assert_win_is_cand_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> cand[win_idx] && pend[win_idx] && !mask[win_idx] && en[win_idx]);
  assert_win_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> win_lvl == ctrl[win_idx] && win_lvl != '0);
  assert_vec_map_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |=> irq_vector_o == 8'($past(win_idx)) + 8'(VEC_BASE) && irq_level_o == $past(win_lvl));
  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any |=> irq_level_o == '0 && irq_vector_o == 8'(SPUR_VEC));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  lvl, vec;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_level_o(lvl), .irq_vector_o(vec)
  );

  // {irq pattern, expected level, expected vector}
  // programmed bytes: src0=1 src5=7 src10=7 src20=3 src63=3, src40 disabled
  localparam logic [79:0] TBL [9] = '{
    {64'h0,                   8'd0, 8'd24},
    {64'h1,                   8'd1, 8'd64},
    {64'h21,                  8'd7, 8'd69},
    {64'h420,                 8'd7, 8'd74},
    {64'h8000_0000_0010_0000, 8'd3, 8'd127},
    {64'h0000_0100_0000_0000, 8'd0, 8'd24},
    {64'h0000_0100_0010_0000, 8'd3, 8'd84},
    {64'h8000_0000_0000_0001, 8'd3, 8'd127},
    {64'hFFFF_FFFF_FFFF_FFFF, 8'd7, 8'd74}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [7:0] el, input logic [7:0] ev);
    chk({tag, " level"}, {24'h0, lvl}, {24'h0, el});
    chk({tag, " vector"}, {24'h0, vec}, {24'h0, ev});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rdr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    req = 1'b0;
  endtask

  task automatic settle;  // one more edge so the output register catches up
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk_out("R10 reset", 8'd0, 8'd24);
    rdr(8'h08, rd); chk("R10 mask hi", rd, 32'hFFFF_FFFF);
    rdr(8'h0C, rd); chk("R10 mask lo", rd, 32'hFFFF_FFFF);
    rdr(8'h04, rd); chk("R10 pend lo", rd, 32'h0);
    rdr(8'h45, rd); chk("R10 ctrl5", rd, 32'h0);
    rdr(8'hE0, rd); chk("R10 swack", rd, 32'd24);

    // setup for the table
    wr(8'h1D, 32'h40);
    wr(8'h40, 32'd1); wr(8'h45, 32'd7); wr(8'h4A, 32'd7);
    wr(8'h54, 32'd3); wr(8'h7F, 32'd3); wr(8'h68, 32'd0);
    rdr(8'h45, rd); chk("R3 ctrl5 readback", rd, 32'd7);

    for (int k = 0; k < 9; k++) begin
      @(negedge clk);
      irq = TBL[k][79:16];
      @(negedge clk);  // pending captured, outputs not yet
      if (k == 1) chk_out("R11 input lag", 8'd0, 8'd24);
      @(negedge clk);
      chk_out($sformatf("R4 R5 R2 row %0d", k), TBL[k][15:8], TBL[k][7:0]);
    end

    // R6 mask halves, irq all ones
    wr(8'h0C, 32'h0000_0400); settle;
    chk_out("R6 mask lo blocks src10", 8'd7, 8'd69);
    rdr(8'h0C, rd); chk("R6 mask lo readback", rd, 32'h0000_0400);
    wr(8'h1D, 32'h40);
    @(negedge clk); irq = 64'h8000_0000_0010_0000;
    wr(8'h08, 32'h8000_0000); settle; settle;
    chk_out("R6 mask hi blocks src63", 8'd3, 8'd84);
    rdr(8'h08, rd); chk("R6 mask hi readback", rd, 32'h8000_0000);

    // R8 clear all, R7/R8 single bit on the tie winner
    wr(8'h1D, 32'h40);
    rdr(8'h08, rd); chk("R8 clear all hi", rd, 32'h0);
    @(negedge clk); irq = '1;
    settle; settle;
    chk_out("R8 all clear tie", 8'd7, 8'd74);
    wr(8'h1C, 32'h0A); settle;
    chk_out("R7 single set masks src10", 8'd7, 8'd69);
    rdr(8'h0C, rd); chk("R7 single set bit", rd, 32'h0000_0400);
    wr(8'h1D, 32'h0A); settle;
    chk_out("R8 single clear", 8'd7, 8'd74);
    rdr(8'h0C, rd); chk("R8 single clear bit", rd, 32'h0);
    wr(8'h1C, 32'h40); settle;
    chk_out("R7 set all", 8'd0, 8'd24);
    rdr(8'h08, rd); chk("R7 set all hi", rd, 32'hFFFF_FFFF);
    wr(8'h1D, 32'h40); settle;

    // R11 one-clock lag after a control write
    wr(8'h54, 32'd9);
    chk_out("R11 before edge", 8'd7, 8'd74);
    settle;
    chk_out("R11 after edge", 8'd9, 8'd84);
    // R3 zero disables
    wr(8'h54, 32'd0); settle;
    chk_out("R3 disable src20", 8'd7, 8'd74);
    rdr(8'h54, rd); chk("R3 ctrl20 zero", rd, 32'h0);

    // R1 pending readback, writes ignored
    @(negedge clk); irq = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    rdr(8'h00, rd); chk("R1 pend hi", rd, 32'hDEAD_BEEF);
    rdr(8'h04, rd); chk("R1 pend lo", rd, 32'h0123_4567);
    wr(8'h04, 32'h0);
    rdr(8'h04, rd); chk("R1 pend write ignored", rd, 32'h0123_4567);

    // R9 reads
    @(negedge clk); irq = 64'h20;
    settle; settle;
    rdr(8'hE0, rd); chk("R9 swack", rd, 32'd69);
    rdr(8'hE3, rd); chk("R9 level ack zero", rd, 32'h0);
    rdr(8'h10, rd); chk("R2 force hi zero", rd, 32'h0);
    rdr(8'h14, rd); chk("R2 force lo zero", rd, 32'h0);
    rdr(8'hA0, rd); chk("R9 unmapped zero", rd, 32'h0);

    // R12 unmapped writes
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); wr(8'hE0, 32'hFF);
    settle;
    chk_out("R12 outputs kept", 8'd7, 8'd69);
    rdr(8'h0C, rd); chk("R12 mask lo kept", rd, 32'h0);
    rdr(8'h08, rd); chk("R12 mask hi kept", rd, 32'h0);
    rdr(8'h45, rd); chk("R12 ctrl kept", rd, 32'd7);

    // R10 reset mid-run with requests high
    @(negedge clk); rst_n = 1'b0; irq = '1;
    @(negedge clk); rst_n = 1'b1;
    chk_out("R10 rerun reset", 8'd0, 8'd24);
    rdr(8'h0C, rd); chk("R10 rerun mask", rd, 32'hFFFF_FFFF);
    rdr(8'h4A, rd); chk("R10 rerun ctrl", rd, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule